// File: doc/BRIEF.md
# Spanning-Tree Port Forwarding Filter

This block sits after the address lookup of a five-port switch and applies spanning-tree gating to each forwarding decision. Ports 1 to 4 face the network. Port 5 is fixed as the processor port. Each request carries the ingress port number, the destination mask produced by lookup, and a flag pair that marks a static-table hit and its override bit. The block answers one cycle later with the final egress mask, a strobe that permits learning of the source address, and a drop flag.

Each network port holds three control bits: transmit enable, receive enable and learning disable. A narrow write port sets them. Software puts a port into the disabled, blocking or listening state by writing transmit enable 0, receive enable 0 and learning disable 1. In these states ordinary traffic is cut off in both directions. Frames that hit a static entry with the override bit still reach the processor, and frames injected by the processor may still leave on the port.

Top module: `stp_gate_top`

## Requirements
- R1: Reset sets every network port to the forwarding state: transmit enable 1, receive enable 1 and learning disable 0. While reset is held, decValid, egressMask, learnOk and dropFlag are all 0.
- R2: A request sampled with reqValid high produces decValid 1 and its decision on the next clock edge. A cycle without a request produces decValid 0 with egressMask 0, learnOk 0 and dropFlag 0. Back-to-back requests each get their own decision, and a held request gives an unchanged decision.
- R3: The ingress port is always cleared from egressMask. Mask bit i-1 stands for port i, so bit 4 is the processor port.
- R4: For a frame from ports 1 to 4, every port whose transmit enable is 0 is cleared from egressMask. No bit outside reqDstMask is set unless an override hit applies.
- R5: A frame from a network port whose receive enable is 0, with no override hit, gives dropFlag 1, egressMask 0 and learnOk 0. An ingress number outside 1..5 is dropped the same way.
- R6: An override hit (reqStaticHit and reqOverride both 1) on a frame from ports 1 to 4 gives egressMask 5'b10000 and dropFlag 0, whatever the ingress receive enable. reqOverride without reqStaticHit has no effect.
- R7: learnOk is 1 for an undropped decision when the ingress is port 5, or when the ingress port's learning disable is 0. Otherwise learnOk is 0.
- R8: With cfgWrEn 1 and cfgPort in 1..4, cfgData is stored for that port: bit 0 is transmit enable, bit 1 is receive enable and bit 2 is learning disable. A request sampled on the same edge still uses the old bits. Writes to cfgPort 0, 5, 6 or 7 are ignored.
- R9: Frames from port 5 ignore transmit enable. A port set to 3'b100 therefore still receives frames injected by the processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Control-bit write strobe |
| cfgPort | input | 3 | Port number written (1..4 valid) |
| cfgData | input | 3 | {learning disable, receive enable, transmit enable} |
| reqValid | input | 1 | Decision request valid |
| reqSrcPort | input | 3 | Ingress port number (1..5) |
| reqDstMask | input | 5 | Destination mask from lookup |
| reqStaticHit | input | 1 | Lookup hit a static entry |
| reqOverride | input | 1 | Override bit of that static entry |
| decValid | output | 1 | Decision valid |
| egressMask | output | 5 | Final egress port mask |
| learnOk | output | 1 | Source address may be learned |
| dropFlag | output | 1 | Frame dropped at ingress |

## Verification
The assertions assume that all request inputs are 0 while reset is held. Their $past terms look at the cycle before the first live edge, and so they rely on that cycle holding no request. The override and echo properties also assume the ingress number stays in 1..5. Random stimulus draws the ingress from that range and mixes in writes to every cfgPort value, valid or not. The directed cases drive the disabled-state and override corners, then bring the state of an ignored write out through later decisions.

// File: rtl/stp_gate_pkg.sv
package stp_gate_pkg;
  localparam int NUM_PORTS = 5;
  localparam int NET_PORTS = NUM_PORTS - 1;
  localparam int CPU_PORT  = NUM_PORTS;
  localparam int PORT_W    = $clog2(NUM_PORTS + 1);
  localparam int CFG_W     = 3;

  // strobes from control to datapath for one request
  typedef struct packed {
    logic                 take;
    logic                 drop;
    logic                 toCpuOnly;
    logic                 learn;
    logic [NUM_PORTS-1:0] allowMask;
  } gateStrobe_t;
endpackage

// File: rtl/stp_gate_ctrl.sv
module stp_gate_ctrl
  import stp_gate_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [PORT_W-1:0]    cfgPort,
  input  logic [CFG_W-1:0]     cfgData,
  input  logic                 reqValid,
  input  logic [PORT_W-1:0]    reqSrcPort,
  input  logic                 reqStaticHit,
  input  logic                 reqOverride,
  output gateStrobe_t          strobe
);
  logic [NET_PORTS-1:0] txEn;
  logic [NET_PORTS-1:0] rxEn;
  logic [NET_PORTS-1:0] learnDis;

  // per-port control bits, reset to forwarding (R1, R8)
  for (genvar p = 0; p < NET_PORTS; p++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        txEn[p]     <= 1'b1;
        rxEn[p]     <= 1'b1;
        learnDis[p] <= 1'b0;
      end else if (cfgWrEn && cfgPort == PORT_W'(p + 1)) begin
        txEn[p]     <= cfgData[0];
        rxEn[p]     <= cfgData[1];
        learnDis[p] <= cfgData[2];
      end
    end
  end

  logic                 srcIsCpu;
  logic                 srcIsNet;
  logic                 srcRx;
  logic                 srcLearnDis;
  logic                 ovrHit;
  logic [NUM_PORTS-1:0] srcOneHot;

  always_comb begin
    srcIsCpu    = (reqSrcPort == PORT_W'(CPU_PORT));
    srcIsNet    = (reqSrcPort >= PORT_W'(1)) && (reqSrcPort <= PORT_W'(NET_PORTS));
    ovrHit      = reqStaticHit & reqOverride;
    srcRx       = 1'b0;
    srcLearnDis = 1'b0;
    for (int p = 0; p < NET_PORTS; p++) begin
      if (reqSrcPort == PORT_W'(p + 1)) begin
        srcRx       = rxEn[p];
        srcLearnDis = learnDis[p];
      end
    end
    for (int i = 0; i < NUM_PORTS; i++) begin
      srcOneHot[i] = (reqSrcPort == PORT_W'(i + 1));
    end
  end

  always_comb begin
    strobe.take      = reqValid;
    strobe.drop      = !srcIsCpu && !(srcIsNet && (srcRx || ovrHit));
    strobe.toCpuOnly = srcIsNet && ovrHit;
    strobe.learn     = !strobe.drop && (srcIsCpu || !srcLearnDis);
    for (int p = 0; p < NET_PORTS; p++) begin
      strobe.allowMask[p] = (txEn[p] | srcIsCpu) & ~srcOneHot[p];
    end
    strobe.allowMask[CPU_PORT-1] = ~srcOneHot[CPU_PORT-1];
  end
endmodule

// File: rtl/stp_gate_dp.sv
module stp_gate_dp
  import stp_gate_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  gateStrobe_t          strobe,
  input  logic [NUM_PORTS-1:0] reqDstMask,
  output logic                 decValid,
  output logic [NUM_PORTS-1:0] egressMask,
  output logic                 learnOk,
  output logic                 dropFlag
);
  localparam logic [NUM_PORTS-1:0] CPU_BIT = NUM_PORTS'(1) << (CPU_PORT - 1);

  logic [NUM_PORTS-1:0] nextMask;

  always_comb begin
    if (strobe.drop)
      nextMask = '0;
    else if (strobe.toCpuOnly)
      nextMask = CPU_BIT & strobe.allowMask;
    else
      nextMask = reqDstMask & strobe.allowMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.take) begin
      decValid   <= 1'b0;
      egressMask <= '0;
      learnOk    <= 1'b0;
      dropFlag   <= 1'b0;
    end else begin
      decValid   <= 1'b1;
      egressMask <= nextMask;
      learnOk    <= strobe.learn;
      dropFlag   <= strobe.drop;
    end
  end
endmodule

// File: rtl/stp_gate_top.sv
module stp_gate_top
  import stp_gate_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [PORT_W-1:0]    cfgPort,
  input  logic [CFG_W-1:0]     cfgData,
  input  logic                 reqValid,
  input  logic [PORT_W-1:0]    reqSrcPort,
  input  logic [NUM_PORTS-1:0] reqDstMask,
  input  logic                 reqStaticHit,
  input  logic                 reqOverride,
  output logic                 decValid,
  output logic [NUM_PORTS-1:0] egressMask,
  output logic                 learnOk,
  output logic                 dropFlag
);
  gateStrobe_t strobe;

  stp_gate_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWrEn      (cfgWrEn),
    .cfgPort      (cfgPort),
    .cfgData      (cfgData),
    .reqValid     (reqValid),
    .reqSrcPort   (reqSrcPort),
    .reqStaticHit (reqStaticHit),
    .reqOverride  (reqOverride),
    .strobe       (strobe)
  );

  stp_gate_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqDstMask (reqDstMask),
    .decValid   (decValid),
    .egressMask (egressMask),
    .learnOk    (learnOk),
    .dropFlag   (dropFlag)
  );
endmodule

// File: rtl/stp_gate_chk.sv
module stp_gate_chk
  import stp_gate_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic [PORT_W-1:0]    reqSrcPort,
  input logic [NUM_PORTS-1:0] reqDstMask,
  input logic                 reqStaticHit,
  input logic                 reqOverride,
  input logic                 decValid,
  input logic [NUM_PORTS-1:0] egressMask,
  input logic                 learnOk,
  input logic                 dropFlag
);
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    decValid == $past(reqValid)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |-> (egressMask == '0 && !learnOk && !dropFlag)); // R2

  AST_NO_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && $past(reqSrcPort) >= PORT_W'(1) && $past(reqSrcPort) <= PORT_W'(NUM_PORTS))
    |-> ((egressMask & (NUM_PORTS'(1) << ($past(reqSrcPort) - PORT_W'(1)))) == '0)); // R3

  AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !$past(reqStaticHit && reqOverride))
    |-> ((egressMask & ~$past(reqDstMask)) == '0)); // R4

  AST_DROP_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    dropFlag |-> (egressMask == '0 && !learnOk)); // R5

  AST_OVERRIDE_CPU: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && $past(reqStaticHit && reqOverride)
     && $past(reqSrcPort) >= PORT_W'(1) && $past(reqSrcPort) <= PORT_W'(NET_PORTS))
    |-> (egressMask == (NUM_PORTS'(1) << (CPU_PORT - 1)) && !dropFlag)); // R6

  AST_CPU_SRC_LEARN: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && $past(reqSrcPort) == PORT_W'(CPU_PORT)) |-> (!dropFlag && learnOk)); // R7
endmodule

bind stp_gate_top stp_gate_chk chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqSrcPort   (reqSrcPort),
  .reqDstMask   (reqDstMask),
  .reqStaticHit (reqStaticHit),
  .reqOverride  (reqOverride),
  .decValid     (decValid),
  .egressMask   (egressMask),
  .learnOk      (learnOk),
  .dropFlag     (dropFlag)
);

// File: tb/stp_gate_tb.sv
`timescale 1ns/1ps
module stp_gate_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [2:0] cfgPort = '0;
  logic [2:0] cfgData = '0;
  logic       reqValid = 1'b0;
  logic [2:0] reqSrcPort = '0;
  logic [4:0] reqDstMask = '0;
  logic       reqStaticHit = 1'b0;
  logic       reqOverride = 1'b0;
  logic       decValid;
  logic [4:0] egressMask;
  logic       learnOk;
  logic       dropFlag;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic mTx [1:4];
  logic mRx [1:4];
  logic mLd [1:4];

  logic [7:0] pendExp;
  string      pendTag;
  bit         pendOn = 0;

  always #2 clk = ~clk;

  stp_gate_top dut_i (.*);

  // expected {valid, drop, learn, mask}
  function automatic logic [7:0] model(input logic v, input logic [2:0] src,
                                       input logic [4:0] dst, input logic hit,
                                       input logic ovr);
    logic isCpu, isNet, ovrHit, drop, learn, rx, ld;
    logic [4:0] mask;
    if (!v) return 8'h00;
    isCpu  = (src == 3'd5);
    isNet  = (src >= 3'd1 && src <= 3'd4);
    ovrHit = hit && ovr;
    rx = 1'b0; ld = 1'b0;
    if (isNet) begin rx = mRx[int'(src)]; ld = mLd[int'(src)]; end
    drop = !isCpu && !(isNet && (rx || ovrHit));
    if (drop) mask = 5'b0;
    else if (isNet && ovrHit) mask = 5'b10000;
    else begin
      mask = dst;
      for (int p = 1; p <= 4; p++) if (!isCpu && !mTx[p]) mask[p-1] = 1'b0;
      mask[int'(src) - 1] = 1'b0;
    end
    learn = !drop && (isCpu || !ld);
    return {1'b0, 1'b1, drop, learn, mask};
  endfunction

  task automatic checkPending();
    if (pendOn) begin
      total++;
      if ({1'b0, decValid, dropFlag, learnOk, egressMask} !== pendExp) begin
        bad++;
        $display("FAIL %s: got v=%b drop=%b learn=%b mask=%b exp v=%b drop=%b learn=%b mask=%b",
                 pendTag, decValid, dropFlag, learnOk, egressMask,
                 pendExp[6], pendExp[5], pendExp[4], pendExp[3:0] == 4'h0 && pendExp[4:0] == 5'h0 ? 5'h0 : pendExp[4:0]);
      end
    end
  endtask

  task automatic step(input logic wr, input logic [2:0] wp, input logic [2:0] wd,
                      input logic v, input logic [2:0] src, input logic [4:0] dst,
                      input logic hit, input logic ovr, input string tag);
    @(negedge clk);
    checkPending();
    cfgWrEn = wr; cfgPort = wp; cfgData = wd;
    reqValid = v; reqSrcPort = src; reqDstMask = dst;
    reqStaticHit = hit; reqOverride = ovr;
    pendExp = model(v, src, dst, hit, ovr);
    pendTag = tag;
    pendOn  = 1;
    if (wr && wp >= 3'd1 && wp <= 3'd4) begin
      mTx[int'(wp)] = wd[0]; mRx[int'(wp)] = wd[1]; mLd[int'(wp)] = wd[2];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    for (int p = 1; p <= 4; p++) begin mTx[p] = 1; mRx[p] = 1; mLd[p] = 0; end
    repeat (3) @(negedge clk);
    total++;
    if ({decValid, dropFlag, learnOk, egressMask} !== 8'h0) begin
      bad++;
      $display("FAIL R1: got %b exp 00000000", {decValid, dropFlag, learnOk, egressMask});
    end
    rstN = 1'b1;
    // R1 defaults: forwarding everywhere
    step(0, 0, 0, 1, 3'd1, 5'b11111, 0, 0, "R1 default forward");
    step(0, 0, 0, 1, 3'd4, 5'b01111, 0, 0, "R3 no echo");
    // R8 write port 2 to 3'b100 while a request is sampled: old bits used
    step(1, 3'd2, 3'b100, 1, 3'd1, 5'b11111, 0, 0, "R8 same-edge old config");
    step(0, 0, 0, 1, 3'd1, 5'b11111, 0, 0, "R4 tx disabled removed");
    step(0, 0, 0, 1, 3'd2, 5'b00001, 0, 0, "R5 rx disabled drop");
    step(0, 0, 0, 1, 3'd2, 5'b00001, 1, 1, "R6 override to cpu");
    step(0, 0, 0, 1, 3'd2, 5'b00001, 0, 1, "R6 override without hit");
    step(0, 0, 0, 1, 3'd5, 5'b00010, 0, 0, "R9 cpu inject to blocked port");
    // R8 ignored writes
    step(1, 3'd0, 3'b000, 0, 0, 0, 0, 0, "R2 idle");
    step(1, 3'd5, 3'b000, 0, 0, 0, 0, 0, "R2 idle");
    step(1, 3'd7, 3'b000, 1, 3'd1, 5'b11111, 0, 0, "R8 ignored write");
    step(0, 0, 0, 1, 3'd3, 5'b11111, 0, 0, "R8 ignored write keeps port1");
    step(0, 0, 0, 1, 3'd3, 5'b00011, 1, 1, "R6 override narrows");
    step(1, 3'd3, 3'b011, 1, 3'd3, 5'b00011, 0, 0, "R7 learn before disable");
    step(1, 3'd3, 3'b111, 1, 3'd3, 5'b00011, 0, 0, "R7 learn still clear");
    step(0, 0, 0, 1, 3'd3, 5'b00011, 0, 0, "R7 learning disabled");
    step(0, 0, 0, 1, 3'd3, 5'b00011, 0, 0, "R2 held request");
    step(0, 0, 0, 1, 3'd6, 5'b11111, 0, 0, "R5 bad ingress");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R2 idle after burst");
    for (int n = 0; n < 4000; n++) begin
      logic wr, v, hit, ovr;
      logic [2:0] wp, wd, src;
      logic [4:0] dst;
      string tag;
      wr  = ($urandom_range(0, 7) == 0);
      wp  = 3'($urandom_range(0, 7));
      wd  = 3'($urandom_range(0, 7));
      v   = ($urandom_range(0, 3) != 0);
      src = 3'($urandom_range(1, 5));
      dst = 5'($urandom_range(0, 31));
      hit = ($urandom_range(0, 3) == 0);
      ovr = 1'($urandom_range(0, 1));
      if (!v) tag = "R2 random idle";
      else if (src == 3'd5) tag = "R9 random cpu source";
      else if (hit && ovr) tag = "R6 random override";
      else if (!mRx[int'(src)]) tag = "R5 random drop";
      else tag = "R4 random forward";
      step(wr, wp, wd, v, src, dst, hit, ovr, tag);
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, "R2 final idle");
    @(negedge clk);
    checkPending();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule